// File: doc/BRIEF.md
# Bus-Line Deglitch Filter

This block cleans the single open-drain CEC wire after it enters a synchronous clock domain. The raw level passes through a two-stage synchroniser. A qualifier then forwards a new level only after the level has held for a programmable number of sampling ticks. Any shorter excursion in either direction is discarded, so the bit-timing decoder downstream sees only real bus transitions.

A 2-bit select picks one of four tick rates, all derived from the system (crystal) clock: every third clock, once per microsecond, once per ten microseconds, or once per hundred microseconds. A 3-bit delay value D sets the minimum width to 3·D ticks. A delay of zero turns qualification off. The usual setting is the 1 µs tick with D = 7, which discards anything shorter than 21 µs.

Top module: `line_deglitch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output is driven to the idle-high level (1) and all internal counts are cleared.
- R2: The raw line is retimed by two flops before filtering. With delay 0, `line_o` equals the value `line_i` had three rising edges earlier.
- R3: Tick select encodings: 0 gives a tick every 3 clocks, 1 every CLKS_PER_US clocks, 2 every 10·CLKS_PER_US clocks and 3 every 100·CLKS_PER_US clocks. Tick k (k ≥ 1) of period P falls in the cycle that precedes edge k·P after reset release, and tick phase does not depend on the select.
- R4: With delay 0, every change of the synchronised level is passed on, including a one-clock pulse.
- R5: With delay D > 0, a differing synchronised level is adopted once it has been present on 3·D ticks. An excursion that covers fewer ticks is ignored. The output changes only at an edge whose preceding cycle carried a tick.
- R6: When the synchronised level returns to the current output value before the threshold is reached, the tick count restarts from zero. Two short excursions separated by a single clock therefore never add up.
- R7: With select 1 and delay 7, a low pulse of 20 µs or less is rejected and one of 22 µs is accepted.
- R8: Qualification applies equally to falling and rising changes, so a short high glitch on a low line is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (crystal) clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Raw bus line, asynchronous to clk |
| tick_sel_i | input | 2 | Sampling tick rate select (R3 encoding) |
| dly_i | input | 3 | Minimum width in groups of three ticks; 0 disables filtering |
| line_o | output | 1 | Filtered line level |

## Verification
Each tick rate is driven with a pulse spanning two tick periods and another spanning four, with delay 1. These separate a correct divider from one that is off by a decade or by the base divide. The normal configuration is driven with pulses just under and just over 21 µs. A pair of short lows split by a one-clock high shows whether the count really restarts or merely pauses. High glitches on a low line and a one-clock pulse with delay 0 cover the reverse direction and the bypass. A behavioural model advanced on every clock checks the exact edge at which each level is accepted.

// File: rtl/dg_pkg.sv
// Shared types and constants for the bus-line deglitch filter.
package dg_pkg;

    // Sampling tick rate select encoding.
    typedef enum logic [1:0] {
        TICK_XTAL3 = 2'd0,
        TICK_1US   = 2'd1,
        TICK_10US  = 2'd2,
        TICK_100US = 2'd3
    } tick_sel_e;

    // Ratio between consecutive slow tick rates.
    localparam int DECADE = 10;

    // Number of decade stages after the microsecond tick.
    localparam int DEC_STAGES = 2;

endpackage

// File: rtl/dg_sync.sv
// Two-flop synchroniser for the raw bus line.
// Assumes: the input may change at any time relative to clk; the reset value is
// the bus idle level so no false edge follows reset.
module dg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    logic meta_q;

    // Retime the asynchronous line through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            lvl_o  <= 1'b1;
        end else begin
            meta_q <= raw_i;
            lvl_o  <= meta_q;
        end
    end
endmodule

// File: rtl/dg_tick_gen.sv
// Free-running sampling tick generator.
// Produces single-cycle pulses every BASE_DIV clocks, or every CLKS_PER_US,
// 10x and 100x that, chosen by sel_i. All counters run continuously, so a
// change of select never shifts the phase of any rate.
// Assumes: BASE_DIV >= 2 and CLKS_PER_US >= 2.
module dg_tick_gen
    import dg_pkg::*;
#(
    parameter int BASE_DIV    = 3,
    parameter int CLKS_PER_US = 24
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tick_sel_e sel_i,
    output logic      tick_o
);
    localparam int BW = $clog2(BASE_DIV);
    localparam int UW = $clog2(CLKS_PER_US);
    localparam int DW = $clog2(DECADE);
    localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);
    localparam logic [UW-1:0] US_LAST   = UW'(CLKS_PER_US - 1);
    localparam logic [DW-1:0] DEC_LAST  = DW'(DECADE - 1);

    logic [BW-1:0] base_cnt;
    logic [UW-1:0] us_cnt;
    logic          base_tick;
    logic [DEC_STAGES:0] stage_tick;

    assign base_tick     = (base_cnt == BASE_LAST);
    assign stage_tick[0] = (us_cnt == US_LAST);

    // Fast divider: one pulse per BASE_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_cnt <= '0;
        else if (base_tick) base_cnt <= '0;
        else                base_cnt <= base_cnt + 1'b1;
    end

    // Microsecond divider.
    always_ff @(posedge clk) begin
        if (!rst_n)             us_cnt <= '0;
        else if (stage_tick[0]) us_cnt <= '0;
        else                    us_cnt <= us_cnt + 1'b1;
    end

    // Chain of decade dividers fed by the microsecond tick.
    for (genvar g = 0; g < DEC_STAGES; g++) begin : g_dec
        logic [DW-1:0] dec_cnt;

        // Count ticks of the previous stage modulo DECADE.
        always_ff @(posedge clk) begin
            if (!rst_n)              dec_cnt <= '0;
            else if (stage_tick[g])  dec_cnt <= (dec_cnt == DEC_LAST) ? '0 : dec_cnt + 1'b1;
        end

        assign stage_tick[g+1] = stage_tick[g] && (dec_cnt == DEC_LAST);
    end

    // Pick the requested rate.
    always_comb begin
        unique case (sel_i)
            TICK_XTAL3: tick_o = base_tick;
            TICK_1US:   tick_o = stage_tick[0];
            TICK_10US:  tick_o = stage_tick[1];
            default:    tick_o = stage_tick[2];
        endcase
    end
endmodule

// File: rtl/dg_qualify.sv
// Width qualifier: adopts a new line level only after it has been present on
// 3*dly_i consecutive sampling ticks; restarts the count whenever the level
// matches the current output again. dly_i == 0 bypasses qualification.
// Assumes: lvl_i is already synchronous to clk.
module dg_qualify #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             filt_o
);
    localparam int MAX_NEED = 3 * ((1 << DLY_W) - 1);
    localparam int CW       = $clog2(MAX_NEED + 1);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_next;
    logic [CW-1:0] need;

    assign need     = CW'(dly_i) + CW'({dly_i, 1'b0});
    assign run_next = run_cnt + 1'b1;

    // Count ticks of a differing level and switch once the threshold is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o  <= 1'b1;
            run_cnt <= '0;
        end else if (dly_i == '0) begin
            filt_o  <= lvl_i;
            run_cnt <= '0;
        end else if (lvl_i == filt_o) begin
            run_cnt <= '0;
        end else if (tick_i) begin
            if (run_next >= need) begin
                filt_o  <= lvl_i;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_next;
            end
        end
    end
endmodule

// File: rtl/line_deglitch.sv
// Top of the bus-line deglitch filter: synchroniser, tick generator and
// width qualifier in series.
// Assumes: clk is the crystal-derived system clock with CLKS_PER_US cycles per
// microsecond; the bus idles high.
module line_deglitch
    import dg_pkg::*;
#(
    parameter int BASE_DIV    = 3,
    parameter int CLKS_PER_US = 24,
    parameter int DLY_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [1:0]       tick_sel_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             line_o
);
    logic lvl_sync;
    logic tick;

    dg_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (line_i),
        .lvl_o (lvl_sync)
    );

    dg_tick_gen #(
        .BASE_DIV    (BASE_DIV),
        .CLKS_PER_US (CLKS_PER_US)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (tick_sel_e'(tick_sel_i)),
        .tick_o (tick)
    );

    dg_qualify #(
        .DLY_W (DLY_W)
    ) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_sync),
        .tick_i (tick),
        .dly_i  (dly_i),
        .filt_o (line_o)
    );
endmodule

// File: rtl/dg_checker.sv
// Temporal checks for line_deglitch, attached by bind.
module dg_checker #(
    parameter int DLY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DLY_W-1:0] dly_i,
    input logic             line_o,
    input logic             lvl_sync,
    input logic             tick
);
    // R1
    reset_idle_high_chk: assert property (@(posedge clk) !rst_n |=> line_o);

    // R4
    bypass_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_i == '0) |=> (line_o == $past(lvl_sync)));

    // R5
    change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_i != '0 && !tick) |=> $stable(line_o));

    // R6
    hold_when_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sync == line_o) |=> $stable(line_o));
endmodule

bind line_deglitch dg_checker #(.DLY_W(DLY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dly_i    (dly_i),
    .line_o   (line_o),
    .lvl_sync (lvl_sync),
    .tick     (tick)
);

// File: tb/tb_line_deglitch.sv
module tb_line_deglitch;
    localparam int CLK_PERIOD = 10;
    localparam int US         = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b1;
    logic [1:0] tick_sel_i = 2'd0;
    logic [2:0] dly_i = 3'd0;
    logic       line_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    line_deglitch #(.BASE_DIV(3), .CLKS_PER_US(US), .DLY_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .tick_sel_i(tick_sel_i), .dly_i(dly_i), .line_o(line_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model, advanced at each rising edge.
    logic q[$];
    logic mf = 1'b1;
    int   run = 0;
    int   n = 0;
    bit   cmp_en = 0;

    function automatic int period(input logic [1:0] s);
        case (s)
            2'd0: return 3;
            2'd1: return US;
            2'd2: return 10 * US;
            default: return 100 * US;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q = {1'b1, 1'b1};
            mf = 1'b1; run = 0; n = 0; cmp_en = 0;
        end else begin
            logic s;
            bit   tk;
            s  = q[0];
            tk = ((n + 1) % period(tick_sel_i)) == 0;
            if (dly_i == 0) begin
                mf = s; run = 0;
            end else if (s == mf) begin
                run = 0;
            end else if (tk) begin
                run++;
                if (run >= 3 * dly_i) begin mf = s; run = 0; end
            end
            q.push_back(line_i);
            void'(q.pop_front());
            n++;
            cmp_en = 1;
        end
    end

    // Per-clock comparison and window observation, away from the edge.
    bit saw_low = 0, saw_high = 0;
    always @(negedge clk) begin
        if (line_o === 1'b0) saw_low = 1;
        if (line_o === 1'b1) saw_high = 1;
        if (cmp_en) begin
            checks++;
            if (line_o !== mf) begin
                errors++;
                $display("FAIL R5 per-clock model: got %b exp %b at cycle %0d", line_o, mf, n);
            end
        end
    end

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b exp %b", req, got, exp);
        end
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic lv, input int w, input logic rest);
        line_i = lv;
        idle(w);
        line_i = rest;
    endtask

    task automatic clear_win();
        saw_low = 0; saw_high = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        check("R1 reset level", line_o, 1'b1);
        rst_n = 1'b1;
        idle(2);
        check("R1 idle after release", line_o, 1'b1);

        // R2: three-edge latency with delay 0
        tick_sel_i = 2'd0; dly_i = 3'd0;
        line_i = 1'b0;
        idle(2);
        check("R2 still high after two edges", line_o, 1'b1);
        idle(1);
        check("R2 low after three edges", line_o, 1'b0);
        line_i = 1'b1;
        idle(6);

        // R4: single-clock pulse passes with delay 0
        clear_win();
        pulse(1'b0, 1, 1'b1);
        idle(6);
        check("R4 one-clock pulse seen", saw_low, 1'b1);

        // R3/R5: each tick rate with delay 1
        dly_i = 3'd1;
        for (int s = 0; s < 4; s++) begin
            int p;
            tick_sel_i = 2'(s);
            p = period(2'(s));
            idle(p + 4);
            clear_win();
            pulse(1'b0, 2 * p, 1'b1);
            idle(2 * p + 10);
            check($sformatf("R3 sel %0d short pulse rejected", s), saw_low, 1'b0);
            clear_win();
            pulse(1'b0, 4 * p, 1'b1);
            check($sformatf("R5 sel %0d long pulse accepted", s), saw_low, 1'b1);
            idle(5 * p + 10);
            check($sformatf("R8 sel %0d returns high", s), line_o, 1'b1);
        end

        // R8: short high glitch on a low line ignored
        tick_sel_i = 2'd0; dly_i = 3'd1;
        line_i = 1'b0;
        idle(20);
        check("R8 line settled low", line_o, 1'b0);
        clear_win();
        pulse(1'b1, 6, 1'b0);
        idle(16);
        check("R8 high glitch ignored", saw_high, 1'b0);
        line_i = 1'b1;
        idle(20);
        check("R8 back high", line_o, 1'b1);

        // R7: normal configuration, 1 us tick and delay 7
        tick_sel_i = 2'd1; dly_i = 3'd7;
        idle(10);
        clear_win();
        pulse(1'b0, 20 * US, 1'b1);
        idle(40 * US);
        check("R7 20us pulse rejected", saw_low, 1'b0);
        clear_win();
        pulse(1'b0, 22 * US, 1'b1);
        idle(30 * US);
        check("R7 22us pulse accepted", saw_low, 1'b1);
        check("R7 returns high", line_o, 1'b1);

        // R6: count restarts on a one-clock return to the output level
        tick_sel_i = 2'd0; dly_i = 3'd2;
        idle(30);
        clear_win();
        pulse(1'b0, 15, 1'b1);
        idle(1);
        pulse(1'b0, 15, 1'b1);
        idle(30);
        check("R6 split pulses rejected", saw_low, 1'b0);
        clear_win();
        pulse(1'b0, 20, 1'b1);
        idle(30);
        check("R6 unbroken pulse accepted", saw_low, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule